// File: doc/BRIEF.md
# Memory Dependence Tracking Unit

This block sits next to an out-of-order issue queue and decides when each in-flight memory operation may issue. Operations are loads, stores, atomics, full barriers, write barriers and transactional commands. Each one is entered into a small table with its sequence number and thread number. The block then keeps, for every entry, the set of older entries it must wait for. It announces an entry as ready once that set is empty and its register operands are available.

Ordering comes from two views of the outstanding barriers and from an optional producer sequence number supplied by an external predictor. Barriers that order loads are tracked apart from barriers that order stores. Addresses are never compared. When a store-like producer completes, it releases all of its dependents in one cycle. The block also supports two recovery paths. A replay list re-announces chosen entries in the order they were queued. A squash removes one thread's entries that are younger than a given point.

All control arrives on one command bus, one command per cycle. Entries are named by sequence number. Sequence numbers are unique, they increase with program age, and a smaller number is older.

Top module: `memdep_unit`

## Requirements
- R1: After reset `rdy_valid` is 0, `drained` is 1 and the table is empty.
- R2: At most one ready notification (`rdy_valid` with `rdy_seq`/`rdy_tid`) is emitted per cycle. Among normally eligible entries the smallest sequence number goes first. An entry is announced once, and again only through the replay list. A notification appears two clock edges after the command that made the entry eligible.
- R3: Commands use `cmd_op` codes 1 insert, 2 registers-ready, 3 complete, 4 replay, 5 replay-all, 6 squash, 0 idle. An inserted entry with no counted producers is announced once its registers are ready. Readiness is given either by `cmd_regs`=1 at insert or by a later registers-ready command. Until then it stays silent, and this holds for barriers too.
- R4: `cmd_kind` codes are 0 load, 1 store, 2 atomic, 3 full barrier, 4 write barrier, 5 transactional command. Kinds 3 and 5 join both the load-ordering and the store-ordering barrier sets. Kind 4 joins only the store-ordering set, so a later load is not held by it.
- R5: A load or atomic inserted while any load-ordering barrier is outstanding waits for every such barrier. Each completion removes one producer, and the entry is announced only after the last one completes.
- R6: If the load case does not apply, a store or atomic inserted while any store-ordering barrier is outstanding waits for every such barrier.
- R7: Otherwise a nonzero `cmd_pred` naming a store-like entry (kind 1 to 5) present in the table is the single producer. A zero value, or a value naming no present store-like entry, gives no dependence.
- R8: A complete command removes the entry. If the entry is store-like it also releases its dependents. A completed barrier leaves the barrier sets it was in.
- R9: A squash removes every entry of `cmd_tid` whose sequence number is greater than `cmd_seq`. This also removes those entries from the barrier sets and purges their queued replays. Entries of other threads are kept.
- R10: A replay command queues an entry. Replay-all then announces every queued entry in queue order, not age order, and empties the queue.
- R11: `drained` is 1 exactly when the table, and with it the replay list, is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command code |
| cmd_kind | input | 3 | Operation kind for insert |
| cmd_seq | input | SEQ_W | Sequence number of the target entry, or the squash point |
| cmd_tid | input | TID_W | Thread number for insert and squash |
| cmd_regs | input | 1 | Registers already ready at insert |
| cmd_pred | input | SEQ_W | Predicted producer sequence number, 0 for none |
| rdy_valid | output | 1 | Ready notification strobe |
| rdy_seq | output | SEQ_W | Sequence number of the announced entry |
| rdy_tid | output | TID_W | Thread of the announced entry |
| drained | output | 1 | Table empty |

## Verification
The bench releases two dependents in the same cycle and expects them one cycle apart, oldest first. A design that merged the two announcements or ordered them by slot would miss the second or name the wrong first one. A load behind two barriers must stay quiet after the first completion, which catches a design that clears all dependences on any single wakeup. A load after a write barrier must issue at once, which catches a design that put write barriers into the load set. Replay-all over entries queued out of age order catches an age-ordered replay. A squash over a mix of threads and a queued replay checks three faults: a wrong-thread kill, a squash that keeps a barrier alive, and a replay that fires after its entry was squashed.

// File: rtl/memdep_unit.sv
module memdep_unit #(
  parameter int N     = 16,
  parameter int NT    = 2,
  parameter int SEQ_W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [2:0]                          cmd_op,
  input  logic [2:0]                          cmd_kind,
  input  logic [SEQ_W-1:0]                    cmd_seq,
  input  logic [(NT > 1 ? $clog2(NT) : 1)-1:0] cmd_tid,
  input  logic                                cmd_regs,
  input  logic [SEQ_W-1:0]                    cmd_pred,
  output logic                                rdy_valid,
  output logic [SEQ_W-1:0]                    rdy_seq,
  output logic [(NT > 1 ? $clog2(NT) : 1)-1:0] rdy_tid,
  output logic                                drained
);
  localparam int TID_W = NT > 1 ? $clog2(NT) : 1;
  localparam int IDX_W = $clog2(N);
  localparam logic [2:0] OP_INS = 3'd1, OP_REGS = 3'd2, OP_DONE = 3'd3,
                         OP_RPL = 3'd4, OP_RALL = 3'd5, OP_SQ = 3'd6;

  logic [N-1:0] v, rr, nt, inrp, go, ldb, stb, stl;
  logic [SEQ_W-1:0] sq [N];
  logic [SEQ_W-1:0] stamp [N];
  logic [TID_W-1:0] td [N];
  logic [N-1:0] dep [N];
  logic [SEQ_W-1:0] rp_cnt;

  logic [N-1:0] hit, phit, dz, sqm, rm, prod;
  logic [IDX_W-1:0] fs, gi, ni, pi;
  logic fs_ok, g_ok, n_ok;

  wire is_ldish = cmd_kind == 3'd0 || cmd_kind == 3'd2;
  wire is_stish = cmd_kind == 3'd1 || cmd_kind == 3'd2;
  wire is_bar   = cmd_kind >= 3'd3;
  wire any_ld   = |(v & ldb);
  wire any_st   = |(v & stb);

  always_comb begin
    fs = '0;
    fs_ok = 1'b0;
    for (int i = 0; i < N; i++) begin
      hit[i]  = v[i] && sq[i] == cmd_seq;
      phit[i] = v[i] && stl[i] && cmd_pred != '0 && sq[i] == cmd_pred;
      sqm[i]  = cmd_op == OP_SQ && v[i] && td[i] == cmd_tid && sq[i] > cmd_seq;
      dz[i]   = 1'b1;
      for (int r = 0; r < N; r++)
        if (dep[r][i]) dz[i] = 1'b0;
      if (!v[i] && !fs_ok) begin
        fs = IDX_W'(i);
        fs_ok = 1'b1;
      end
    end
    rm = sqm | ((cmd_op == OP_DONE) ? hit : '0);
    if (is_ldish && any_ld)      prod = v & ldb;
    else if (is_stish && any_st) prod = v & stb;
    else if (!is_bar)            prod = phit;
    else                         prod = '0;
  end

  always_comb begin
    g_ok = 1'b0; gi = '0;
    n_ok = 1'b0; ni = '0;
    for (int i = 0; i < N; i++) begin
      if (v[i] && go[i] && (!g_ok || stamp[i] < stamp[gi])) begin
        g_ok = 1'b1; gi = IDX_W'(i);
      end
      if (v[i] && rr[i] && dz[i] && !nt[i] && (!n_ok || sq[i] < sq[ni])) begin
        n_ok = 1'b1; ni = IDX_W'(i);
      end
    end
    pi = g_ok ? gi : ni;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v <= '0; rr <= '0; nt <= '0; inrp <= '0; go <= '0;
      ldb <= '0; stb <= '0; stl <= '0; rp_cnt <= '0;
      rdy_valid <= 1'b0; rdy_seq <= '0; rdy_tid <= '0;
      for (int i = 0; i < N; i++) begin
        sq[i] <= '0; stamp[i] <= '0; td[i] <= '0; dep[i] <= '0;
      end
    end else begin
      rdy_valid <= g_ok || n_ok;
      rdy_seq   <= sq[pi];
      rdy_tid   <= td[pi];
      if (g_ok || n_ok) begin
        nt[pi] <= 1'b1;
        go[pi] <= 1'b0;
      end
      case (cmd_op)
        OP_INS: if (fs_ok) begin
          v[fs] <= 1'b1; sq[fs] <= cmd_seq; td[fs] <= cmd_tid;
          rr[fs] <= cmd_regs; nt[fs] <= 1'b0; inrp[fs] <= 1'b0; go[fs] <= 1'b0;
          ldb[fs] <= cmd_kind == 3'd3 || cmd_kind == 3'd5;
          stb[fs] <= is_bar;
          stl[fs] <= cmd_kind != 3'd0;
          dep[fs] <= '0;
          for (int r = 0; r < N; r++) dep[r][fs] <= prod[r];
        end
        OP_REGS: for (int i = 0; i < N; i++) if (hit[i]) rr[i] <= 1'b1;
        OP_RPL: begin
          for (int i = 0; i < N; i++)
            if (hit[i]) begin
              inrp[i] <= 1'b1;
              stamp[i] <= rp_cnt;
            end
          rp_cnt <= rp_cnt + 1'b1;
        end
        OP_RALL: for (int i = 0; i < N; i++)
          if (inrp[i]) begin
            go[i] <= 1'b1;
            inrp[i] <= 1'b0;
          end
        default: ;
      endcase
      for (int i = 0; i < N; i++)
        if (rm[i]) begin
          v[i] <= 1'b0; inrp[i] <= 1'b0; go[i] <= 1'b0; dep[i] <= '0;
        end
    end
  end

  assign drained = ~|v;

  logic last_sq, young_left;
  logic [TID_W-1:0] lsq_tid;
  logic [SEQ_W-1:0] lsq_seq;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_sq <= 1'b0; lsq_tid <= '0; lsq_seq <= '0;
    end else begin
      last_sq <= cmd_op == OP_SQ;
      lsq_tid <= cmd_tid;
      lsq_seq <= cmd_seq;
    end
  end
  always_comb begin
    young_left = 1'b0;
    for (int i = 0; i < N; i++)
      if (v[i] && td[i] == lsq_tid && sq[i] > lsq_seq) young_left = 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !rdy_valid && drained);
  p_no_double_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_valid |=> !(rdy_valid && rdy_seq == $past(rdy_seq)));
  p_squash_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_sq |-> !young_left);
  p_drain_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (drained && cmd_op != OP_INS) |=> !rdy_valid);
endmodule

// File: tb/memdep_unit_tb.sv
module memdep_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd_op = '0, cmd_kind = '0;
  logic [15:0] cmd_seq = '0, cmd_pred = '0;
  logic [0:0] cmd_tid = '0;
  logic cmd_regs = 1'b0;
  logic rdy_valid, drained;
  logic [15:0] rdy_seq;
  logic [0:0] rdy_tid;
  int total = 0, fails = 0;

  always #10 clk = ~clk;

  memdep_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_kind(cmd_kind),
    .cmd_seq(cmd_seq), .cmd_tid(cmd_tid), .cmd_regs(cmd_regs), .cmd_pred(cmd_pred),
    .rdy_valid(rdy_valid), .rdy_seq(rdy_seq), .rdy_tid(rdy_tid), .drained(drained)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  kind;
    logic [15:0] seq;
    logic        tid;
    logic        regs;
    logic [15:0] pred;
    logic [2:0]  n;
    logic [15:0] first;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 3'd1, 16'd10, 1'b0, 1'b1, 16'd0,  3'd1, 16'd10, "R3"},
    '{3'd1, 3'd0, 16'd11, 1'b0, 1'b1, 16'd10, 3'd0, 16'd0,  "R7"},
    '{3'd3, 3'd0, 16'd10, 1'b0, 1'b0, 16'd0,  3'd1, 16'd11, "R8"},
    '{3'd1, 3'd3, 16'd12, 1'b0, 1'b1, 16'd0,  3'd1, 16'd12, "R3"},
    '{3'd1, 3'd1, 16'd13, 1'b0, 1'b1, 16'd0,  3'd0, 16'd0,  "R6"},
    '{3'd1, 3'd0, 16'd14, 1'b0, 1'b1, 16'd0,  3'd0, 16'd0,  "R5"},
    '{3'd3, 3'd0, 16'd12, 1'b0, 1'b0, 16'd0,  3'd2, 16'd13, "R2"},
    '{3'd1, 3'd4, 16'd15, 1'b0, 1'b1, 16'd0,  3'd1, 16'd15, "R4"},
    '{3'd1, 3'd0, 16'd16, 1'b0, 1'b1, 16'd0,  3'd1, 16'd16, "R4"},
    '{3'd1, 3'd1, 16'd17, 1'b0, 1'b0, 16'd0,  3'd0, 16'd0,  "R6"},
    '{3'd2, 3'd0, 16'd17, 1'b0, 1'b0, 16'd0,  3'd0, 16'd0,  "R3"},
    '{3'd3, 3'd0, 16'd15, 1'b0, 1'b0, 16'd0,  3'd1, 16'd17, "R8"},
    '{3'd1, 3'd1, 16'd18, 1'b0, 1'b0, 16'd0,  3'd0, 16'd0,  "R3"},
    '{3'd2, 3'd0, 16'd18, 1'b0, 1'b0, 16'd0,  3'd1, 16'd18, "R3"},
    '{3'd4, 3'd0, 16'd16, 1'b0, 1'b0, 16'd0,  3'd0, 16'd0,  "R10"},
    '{3'd4, 3'd0, 16'd11, 1'b0, 1'b0, 16'd0,  3'd0, 16'd0,  "R10"},
    '{3'd5, 3'd0, 16'd0,  1'b0, 1'b0, 16'd0,  3'd2, 16'd16, "R10"},
    '{3'd1, 3'd3, 16'd22, 1'b0, 1'b0, 16'd0,  3'd0, 16'd0,  "R3"},
    '{3'd4, 3'd0, 16'd17, 1'b0, 1'b0, 16'd0,  3'd0, 16'd0,  "R10"},
    '{3'd1, 3'd1, 16'd23, 1'b1, 1'b1, 16'd0,  3'd0, 16'd0,  "R6"},
    '{3'd6, 3'd0, 16'd16, 1'b0, 1'b0, 16'd0,  3'd1, 16'd23, "R9"},
    '{3'd5, 3'd0, 16'd0,  1'b0, 1'b0, 16'd0,  3'd0, 16'd0,  "R9"},
    '{3'd1, 3'd0, 16'd24, 1'b0, 1'b1, 16'd0,  3'd1, 16'd24, "R9"},
    '{3'd1, 3'd0, 16'd30, 1'b0, 1'b1, 16'd99, 3'd1, 16'd30, "R7"},
    '{3'd1, 3'd4, 16'd31, 1'b0, 1'b1, 16'd0,  3'd1, 16'd31, "R4"},
    '{3'd1, 3'd2, 16'd32, 1'b0, 1'b1, 16'd0,  3'd0, 16'd0,  "R6"},
    '{3'd3, 3'd0, 16'd31, 1'b0, 1'b0, 16'd0,  3'd1, 16'd32, "R6"},
    '{3'd1, 3'd3, 16'd40, 1'b0, 1'b1, 16'd0,  3'd1, 16'd40, "R5"},
    '{3'd1, 3'd3, 16'd41, 1'b0, 1'b1, 16'd0,  3'd1, 16'd41, "R5"},
    '{3'd1, 3'd0, 16'd42, 1'b0, 1'b1, 16'd0,  3'd0, 16'd0,  "R5"},
    '{3'd3, 3'd0, 16'd40, 1'b0, 1'b0, 16'd0,  3'd0, 16'd0,  "R5"},
    '{3'd3, 3'd0, 16'd41, 1'b0, 1'b0, 16'd0,  3'd1, 16'd42, "R5"}
  };

  task automatic chk(input logic [23:0] tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [2:0] kind, input logic [15:0] seq,
                       input logic tid, input logic regs, input logic [15:0] pred);
    @(negedge clk);
    cmd_op = op; cmd_kind = kind; cmd_seq = seq; cmd_tid = tid;
    cmd_regs = regs; cmd_pred = pred;
    @(negedge clk);
    cmd_op = 3'd0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end

  initial begin
    int n, first;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(rdy_valid), 0);
    chk("R1", int'(drained), 1);

    // R2 timing: notification two edges after the insert, carrying the thread
    issue(3'd1, 3'd1, 16'd5, 1'b1, 1'b1, 16'd0);
    chk("R2", int'(rdy_valid), 0);
    chk("R11", int'(drained), 0);
    @(negedge clk);
    chk("R2", int'(rdy_valid), 1);
    chk("R2", int'(rdy_seq), 5);
    chk("R2", int'(rdy_tid), 1);
    issue(3'd3, 3'd0, 16'd5, 1'b1, 1'b0, 16'd0);
    @(negedge clk);
    chk("R11", int'(drained), 1);

    for (int k = 0; k < NV; k++) begin
      issue(VEC[k].op, VEC[k].kind, VEC[k].seq, VEC[k].tid, VEC[k].regs, VEC[k].pred);
      n = 0; first = 0;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (rdy_valid) begin
          if (n == 0) first = int'(rdy_seq);
          n++;
        end
      end
      chk(VEC[k].tag, n, int'(VEC[k].n));
      chk(VEC[k].tag, first, int'(VEC[k].first));
    end

    chk("R11", int'(drained), 0);
    foreach (VEC[k]) ;
    begin
      int left [9] = '{11, 13, 14, 16, 23, 24, 30, 32, 42};
      for (int j = 0; j < 9; j++) begin
        issue(3'd3, 3'd0, 16'(left[j]), 1'b0, 1'b0, 16'd0);
        chk("R8", int'(rdy_valid), 0);
      end
    end
    @(negedge clk);
    chk("R11", int'(drained), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end
endmodule